// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single access requests from a small controller's internal bus into timed external strobe sequences. A request carries a direction, a 3-bit area number and a word address. It is taken only while the block is not busy. It then plays out as a fixed-length basic cycle, where chip select and either the read or the write strobe are held low for `BASIC_ST` bus states.

An 8-bit control register shapes the sequencing in two ways. First, the block remembers the direction and area of the last external access. It can place one quiet bus state ahead of a read that follows a write, or ahead of a read that follows a read to a different area. Second, area 0 can act as a burst ROM port. The first read of a burst gets the full basic cycle. Later reads that stay inside the same aligned block of 4 or 8 words take a short cycle of one or two states, up to a programmable number of words.

The history is captured when each external cycle ends and is cleared by reset. The first access after reset therefore never gets an idle state.

Top module: `xbus_seq`

## Requirements
- R1: After reset the control register reads 0xD0, `busy` and `idle_cyc` are low, and `cs_n`, `rd_n` and `wr_n` are high.
- R2: All 8 control register bits are writable and read back unchanged. Bit 7 enables the read-after-read gap, bit 6 the read-after-write gap, bit 5 enables burst ROM on area 0, bit 4 selects a 2-state (1) or 1-state (0) burst cycle, bit 3 selects an 8-word (1) or 4-word (0) burst limit, and bits 2..0 are plain storage.
- R3: An access accepted while `busy` is low raises `busy` from the next state until the cycle ends. A basic cycle holds `cs_n` low for `BASIC_ST` (default 3) states, with `rd_n` low for a read or `wr_n` low for a write, and never both.
- R4: With bit 6 set, a read whose previous external access was a write gets exactly one idle state first. With bit 6 clear it gets none.
- R5: With bit 7 set, a read whose previous external access was a read to a different area gets one idle state. A read to the same area gets none, and with bit 7 clear neither gets one.
- R6: An idle state lasts exactly one bus state, keeps all strobes high with `idle_cyc` and `busy` high, and is followed directly by the read's strobes.
- R7: Reset clears the access history, so the first access after reset gets no idle state even when the last access before reset was a write.
- R8: With burst ROM enabled, an area 0 read that follows an area 0 read in the same burst and the same aligned block (word address with its low 2 bits, or low 3 bits for an 8-word limit, ignored) uses a short cycle of 1 or 2 states as bit 4 selects.
- R9: A burst holds at most 4 or 8 words as bit 3 selects. The read after the limit is reached, or a read into another aligned block, takes a full basic cycle and starts a new burst.
- R10: A write, an access to another area, an idle state, or burst ROM being disabled ends the burst, so the next area 0 read takes a full basic cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus state clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request, taken when `busy` is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_area | input | 3 | Address area of the access |
| req_addr | input | 8 | Word address of the access |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| cs_n | output | 1 | External chip select, active low |
| rd_n | output | 1 | External read strobe, active low |
| wr_n | output | 1 | External write strobe, active low |
| busy | output | 1 | An idle state or access cycle is in progress |
| idle_cyc | output | 1 | The current bus state is an inserted idle state |

## Verification
The bench varies the access pattern and checks the number of idle states and strobe states for each access. Read after write, read after a read to another area, and read after a read to the same area show whether each gap rule fires only for its own case, and turning both enables off shows that they gate the gaps. Runs of area 0 reads walk through aligned blocks. Separate runs hit the word limit inside a block, cross a block edge before the limit, or are broken by a write, a different area or a gap, so each way a burst can end is seen apart from the others. Both short cycle lengths and both limits are exercised. A reset that lands right after a write shows that the history is cleared.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_GAP   = 2'd1,
    ST_ACC   = 2'd2
  } bus_st_e;

  // packed MSB first: field order is the register bit order
  typedef struct packed {
    logic       gap_rr;     // bit 7
    logic       gap_wr;     // bit 6
    logic       brom_en;    // bit 5
    logic       brst_slow;  // bit 4
    logic       brst_long;  // bit 3
    logic [2:0] spare;      // bits 2..0
  } bus_cfg_t;

  localparam logic [7:0] CFG_RST = 8'hD0;

endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output bus_cfg_t   cfg
);

  bus_cfg_t cfg_q;
  bus_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = bus_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= bus_cfg_t'(CFG_RST);
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/xbus_hist.sv
module xbus_hist #(
  parameter int AREA_W = 3,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              done,
  input  logic              in_write,
  input  logic [AREA_W-1:0] in_area,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_elig,
  input  logic              in_short,
  output logic              prev_valid,
  output logic              prev_write,
  output logic [AREA_W-1:0] prev_area,
  output logic [ADDR_W-1:0] prev_addr,
  output logic              burst_live,
  output logic [CNT_W-1:0]  burst_cnt
);

  // pending copy of the access in flight
  logic              pw_q, pe_q, ps_q;
  logic [AREA_W-1:0] pa_q;
  logic [ADDR_W-1:0] pd_q;

  // committed history
  logic              hv_q, hw_q, bl_q;
  logic [AREA_W-1:0] ha_q;
  logic [ADDR_W-1:0] hd_q;
  logic [CNT_W-1:0]  bc_q;

  logic              bl_d;
  logic [CNT_W-1:0]  bc_d;

  always_comb begin
    bl_d = 1'b0;
    bc_d = '0;
    if (pe_q) begin
      bl_d = 1'b1;
      bc_d = ps_q ? bc_q + CNT_W'(1) : CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q <= 1'b0;
      pe_q <= 1'b0;
      ps_q <= 1'b0;
      pa_q <= '0;
      pd_q <= '0;
    end else if (accept) begin
      pw_q <= in_write;
      pe_q <= in_elig;
      ps_q <= in_short;
      pa_q <= in_area;
      pd_q <= in_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      hw_q <= 1'b0;
      ha_q <= '0;
      hd_q <= '0;
      bl_q <= 1'b0;
      bc_q <= '0;
    end else if (done) begin
      hv_q <= 1'b1;
      hw_q <= pw_q;
      ha_q <= pa_q;
      hd_q <= pd_q;
      bl_q <= bl_d;
      bc_q <= bc_d;
    end
  end

  assign prev_valid = hv_q;
  assign prev_write = hw_q;
  assign prev_area  = ha_q;
  assign prev_addr  = hd_q;
  assign burst_live = bl_q;
  assign burst_cnt  = bc_q;

endmodule

// File: rtl/xbus_plan.sv
module xbus_plan
  import xbus_pkg::*;
#(
  parameter int AREA_W    = 3,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 4,
  parameter int LEN_W     = 2,
  parameter int BASIC_ST  = 3,
  parameter int BURST_SH  = 4,
  parameter int BURST_LG  = 8
) (
  input  bus_cfg_t          cfg,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              prev_valid,
  input  logic              prev_write,
  input  logic [AREA_W-1:0] prev_area,
  input  logic [ADDR_W-1:0] prev_addr,
  input  logic              burst_live,
  input  logic [CNT_W-1:0]  burst_cnt,
  output logic              need_gap,
  output logic              elig,
  output logic              use_short,
  output logic [LEN_W-1:0]  acc_len
);

  localparam logic [ADDR_W-1:0] MASK_SH = ~ADDR_W'(BURST_SH - 1);
  localparam logic [ADDR_W-1:0] MASK_LG = ~ADDR_W'(BURST_LG - 1);

  logic              wr_gap, rr_gap, same_blk, under_lim;
  logic [ADDR_W-1:0] blk_mask;
  logic [CNT_W-1:0]  limit;

  always_comb begin
    wr_gap    = cfg.gap_wr && prev_write;
    rr_gap    = cfg.gap_rr && !prev_write && (prev_area != req_area);
    need_gap  = prev_valid && !req_write && (wr_gap || rr_gap);

    blk_mask  = cfg.brst_long ? MASK_LG : MASK_SH;
    limit     = cfg.brst_long ? CNT_W'(BURST_LG) : CNT_W'(BURST_SH);
    same_blk  = ((req_addr ^ prev_addr) & blk_mask) == '0;
    under_lim = burst_cnt < limit;

    elig      = cfg.brom_en && !req_write && (req_area == '0);
    use_short = elig && !need_gap && burst_live && (prev_area == '0) &&
                same_blk && under_lim;

    if (use_short) acc_len = cfg.brst_slow ? LEN_W'(2) : LEN_W'(1);
    else           acc_len = LEN_W'(BASIC_ST);
  end

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
  import xbus_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             need_gap,
  input  logic [LEN_W-1:0] acc_len,
  output logic             accept,
  output logic             done,
  output logic             busy,
  output logic             idle_cyc,
  output logic             cs_n,
  output logic             rd_n,
  output logic             wr_n
);

  bus_st_e          st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             wr_q, wr_d;
  logic             rem_en;

  assign accept = req_valid && (st_q == ST_READY);
  assign done   = (st_q == ST_ACC) && (rem_q == LEN_W'(1));

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    wr_d   = wr_q;
    rem_en = 1'b0;
    unique case (st_q)
      ST_READY: if (accept) begin
        st_d   = need_gap ? ST_GAP : ST_ACC;
        rem_d  = acc_len;
        wr_d   = req_write;
        rem_en = 1'b1;
      end
      ST_GAP: st_d = ST_ACC;
      ST_ACC: begin
        rem_d  = rem_q - LEN_W'(1);
        rem_en = 1'b1;
        if (done) st_d = ST_READY;
      end
      default: st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_READY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      wr_q  <= 1'b0;
    end else if (rem_en) begin
      rem_q <= rem_d;
      wr_q  <= wr_d;
    end
  end

  assign busy     = (st_q != ST_READY);
  assign idle_cyc = (st_q == ST_GAP);
  assign cs_n     = !(st_q == ST_ACC);
  assign rd_n     = !((st_q == ST_ACC) && !wr_q);
  assign wr_n     = !((st_q == ST_ACC) && wr_q);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AREA_W   = 3,
  parameter int ADDR_W   = 8,
  parameter int BASIC_ST = 3,
  parameter int BURST_SH = 4,
  parameter int BURST_LG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              busy,
  output logic              idle_cyc
);

  localparam int LEN_W = $clog2(BASIC_ST + 1);
  localparam int CNT_W = $clog2(BURST_LG + 1);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bus_cfg_t          cfg;
  logic              prev_valid, prev_write, burst_live;
  logic [AREA_W-1:0] prev_area;
  logic [ADDR_W-1:0] prev_addr;
  logic [CNT_W-1:0]  burst_cnt;
  logic              need_gap, elig, use_short, accept, done;
  logic [LEN_W-1:0]  acc_len;

  xbus_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  assign cfg_rdata = cfg;

  xbus_plan #(
    .AREA_W(AREA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
    .BASIC_ST(BASIC_ST), .BURST_SH(BURST_SH), .BURST_LG(BURST_LG)
  ) u_plan (
    .cfg        (cfg),
    .req_write  (req_write),
    .req_area   (req_area),
    .req_addr   (req_addr),
    .prev_valid (prev_valid),
    .prev_write (prev_write),
    .prev_area  (prev_area),
    .prev_addr  (prev_addr),
    .burst_live (burst_live),
    .burst_cnt  (burst_cnt),
    .need_gap   (need_gap),
    .elig       (elig),
    .use_short  (use_short),
    .acc_len    (acc_len)
  );

  xbus_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .need_gap  (need_gap),
    .acc_len   (acc_len),
    .accept    (accept),
    .done      (done),
    .busy      (busy),
    .idle_cyc  (idle_cyc),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );

  xbus_hist #(.AREA_W(AREA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .done       (done),
    .in_write   (req_write),
    .in_area    (req_area),
    .in_addr    (req_addr),
    .in_elig    (elig),
    .in_short   (use_short),
    .prev_valid (prev_valid),
    .prev_write (prev_write),
    .prev_area  (prev_area),
    .prev_addr  (prev_addr),
    .burst_live (burst_live),
    .burst_cnt  (burst_cnt)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic idle_cyc,
  input logic cs_n,
  input logic rd_n,
  input logic wr_n
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R3
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);

  // R3
  cs_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R3
  take_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cyc |-> (cs_n && rd_n && wr_n && busy));

  // R6
  idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cyc |=> !idle_cyc);

  // R6
  idle_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cyc |=> (!cs_n && !rd_n));

endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .busy      (busy),
  .idle_cyc  (idle_cyc),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n)
);

// File: tb/tb_xbus_seq.sv
`timescale 1ns/1ps
module tb_xbus_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, cfg_we;
  logic [2:0] req_area;
  logic [7:0] req_addr, cfg_wdata, cfg_rdata;
  logic       cs_n, rd_n, wr_n, busy, idle_cyc;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xbus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_area(req_area), .req_addr(req_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .busy(busy), .idle_cyc(idle_cyc)
  );

  // {cfg[8], write, area[3], addr[8], gap, len[2]}
  localparam int NV = 35;
  localparam logic [22:0] VEC [0:NV-1] = '{
    {8'hD0,1'b0,3'd1,8'h00,1'b0,2'd3},  // R7 first access, no history
    {8'hD0,1'b0,3'd2,8'h00,1'b1,2'd3},  // R5 other area
    {8'hD0,1'b0,3'd2,8'h01,1'b0,2'd3},  // R5 same area
    {8'hD0,1'b1,3'd2,8'h02,1'b0,2'd3},  // R3 write
    {8'hD0,1'b0,3'd2,8'h03,1'b1,2'd3},  // R4 read after write
    {8'h10,1'b1,3'd1,8'h00,1'b0,2'd3},  // R3
    {8'h10,1'b0,3'd3,8'h00,1'b0,2'd3},  // R4 disabled
    {8'h10,1'b0,3'd4,8'h00,1'b0,2'd3},  // R5 disabled
    {8'hF0,1'b0,3'd0,8'h10,1'b1,2'd3},  // R8 first of burst after gap
    {8'hF0,1'b0,3'd0,8'h11,1'b0,2'd2},  // R8 2-state
    {8'hF0,1'b0,3'd0,8'h12,1'b0,2'd2},  // R8
    {8'hF0,1'b0,3'd0,8'h13,1'b0,2'd2},  // R8 fourth word
    {8'hF0,1'b0,3'd0,8'h10,1'b0,2'd3},  // R9 4-word limit
    {8'hF0,1'b0,3'd0,8'h14,1'b0,2'd3},  // R9 block edge
    {8'hF0,1'b0,3'd0,8'h15,1'b0,2'd2},  // R8
    {8'hE8,1'b0,3'd0,8'h16,1'b0,2'd1},  // R8 1-state, 8-word block
    {8'hE8,1'b0,3'd0,8'h17,1'b0,2'd1},  // R8
    {8'hE8,1'b0,3'd0,8'h18,1'b0,2'd3},  // R9 block edge
    {8'hE8,1'b1,3'd0,8'h19,1'b0,2'd3},  // R10 write full
    {8'hE8,1'b0,3'd0,8'h1A,1'b1,2'd3},  // R10 after write and gap
    {8'hE8,1'b0,3'd0,8'h1B,1'b0,2'd1},  // R8
    {8'hE8,1'b0,3'd1,8'h00,1'b1,2'd3},  // R5
    {8'hE8,1'b0,3'd0,8'h1C,1'b1,2'd3},  // R10 other area broke burst
    {8'hE8,1'b0,3'd0,8'h20,1'b0,2'd3},  // R9
    {8'hE8,1'b0,3'd0,8'h21,1'b0,2'd1},
    {8'hE8,1'b0,3'd0,8'h22,1'b0,2'd1},
    {8'hE8,1'b0,3'd0,8'h23,1'b0,2'd1},
    {8'hE8,1'b0,3'd0,8'h24,1'b0,2'd1},
    {8'hE8,1'b0,3'd0,8'h25,1'b0,2'd1},
    {8'hE8,1'b0,3'd0,8'h26,1'b0,2'd1},
    {8'hE8,1'b0,3'd0,8'h27,1'b0,2'd1},  // eighth word
    {8'hE8,1'b0,3'd0,8'h20,1'b0,2'd3},  // R9 8-word limit
    {8'hE8,1'b0,3'd0,8'h21,1'b0,2'd1},  // R9 new burst continues
    {8'hC0,1'b0,3'd0,8'h22,1'b0,2'd3},  // R10 burst ROM off
    {8'hC0,1'b0,3'd0,8'h23,1'b0,2'd3}   // R10
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue one access, then count idle and strobe states until busy drops
  task automatic access(input logic wr, input logic [2:0] ar, input logic [7:0] ad,
                        input int exp_gap, input int exp_len, input string tag);
    int gap_n, len_n;
    bit strobe_ok;
    gap_n = 0; len_n = 0; strobe_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_area = ar; req_addr = ad;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) begin
      if (idle_cyc) begin
        gap_n++;
        if (!(cs_n && rd_n && wr_n)) strobe_ok = 1'b0;
      end else begin
        len_n++;
        if (cs_n || (rd_n != wr) || (wr_n != !wr)) strobe_ok = 1'b0;
      end
      @(negedge clk);
    end
    check(gap_n == exp_gap, {tag, " idle states"}, gap_n, exp_gap);
    check(len_n == exp_len, {tag, " strobe states"}, len_n, exp_len);
    check(strobe_ok, "R3/R6 strobe pattern", strobe_ok, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_area = '0;
    req_addr = '0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 8'hD0, "R1 cfg reset", cfg_rdata, 8'hD0);
    check({cs_n, rd_n, wr_n, busy, idle_cyc} == 5'b11100, "R1 outputs",
          {cs_n, rd_n, wr_n, busy, idle_cyc}, 5'b11100);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      if (cfg_rdata != v[22:15]) write_cfg(v[22:15]);
      access(v[14], v[13:11], v[10:3], int'(v[2]), int'(v[1:0]),
             $sformatf("R4/R5/R8/R9/R10 vec%0d", i));
    end

    // R2 full register readback
    write_cfg(8'h2F);
    check(cfg_rdata == 8'h2F, "R2 readback", cfg_rdata, 8'h2F);
    write_cfg(8'hD5);
    check(cfg_rdata == 8'hD5, "R2 readback", cfg_rdata, 8'hD5);

    // R7 history cleared by reset: write, reset, then read
    access(1'b1, 3'd2, 8'h40, 0, 3, "R7 write before reset");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_rdata == 8'hD0, "R1 cfg after reset", cfg_rdata, 8'hD0);
    access(1'b0, 3'd2, 8'h41, 0, 3, "R7 read after reset");
    access(1'b1, 3'd2, 8'h42, 0, 3, "R7 write");
    access(1'b0, 3'd2, 8'h43, 1, 3, "R4 gap restored");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule